// File: doc/BRIEF.md
# Buffered Eight-Bit PWM Channel

This block produces one pulse-width modulated output from an up/down counter, an active period value and an active duty value. It advances only on cycles where the `tick` input is high. The tick stands in for the divided-down channel clock that a wider PWM unit would supply. A small write/read port lets software set the period, the duty, the control bits and the counter.

Period and duty each have two copies. A shadow copy takes every write. An active copy drives the compare logic. While the channel runs, the shadow copy moves into the active copy only when the waveform reaches a safe point. As a result, every output period follows either the old settings or the new settings, and never a mixture of the two.

Two counting shapes are supported. In edge-aligned mode the counter ramps up and wraps. In centre-aligned mode it ramps up and then back down. A polarity bit chooses whether each period starts high or starts low.

Top module: `pwmch_top`

## Requirements
- R1: After reset, the period, duty and counter read 0 and the control register reads 0x02. That value means disabled, polarity 1, edge-aligned. `pwm_out` is 0.
- R2: Edge-aligned mode (control bit 2 = 0) with enable (control bit 0) set: on each tick the counter goes up by one. On the tick after it reaches PER−1 it goes back to 0, so the period is PER ticks.
- R3: Centre-aligned mode (control bit 2 = 1): the counter steps 0,1,…,PER and then PER−1,…,1,0, so the period is 2×PER ticks.
- R4: With polarity bit (control bit 1) = 1, the output is high while the counter is below DTY and low otherwise. On the downward ramp it is high while the counter is at most DTY. Polarity 0 inverts both levels. This gives a high time of DTY/PER with polarity 1 and (PER−DTY)/PER with polarity 0.
- R5: DTY = 0 or PER = 0 holds the output at the inverse of the polarity bit. DTY ≥ PER (with PER > 0) holds it at the polarity bit.
- R6: While enabled, period and duty writes go only to the shadow copies. The active values change only when the counter returns to 0 at the end of a period.
- R7: Any write to the counter (select 2) sets it to 0, restarts the upward ramp and copies the shadow values into the active ones.
- R8: While disabled, period and duty writes reach the active values at once. The counter stays at 0 and the output equals the inverse of the polarity bit.
- R9: Reading period (select 0) or duty (select 1) returns the last value written, even if that value is not yet active. Select 2 reads the counter and select 3 reads the control register.
- R10: A change of the alignment bit takes effect only while the channel is disabled. A change made while the channel is enabled waits until the next disable.
- R11: The counter does not move on cycles without a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Channel clock enable; one count step per high cycle |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 period, 1 duty, 2 counter, 3 control |
| wr_data | input | W | Write value; control uses bits 2:0 (align, polarity, enable) |
| rd_sel | input | 2 | Readback select, same coding as wr_sel |
| rd_data | output | W | Readback value |
| pwm_out | output | 1 | PWM waveform |

## Verification
The bench changes the duty value in the middle of a running period. A design that loads the active copy early would show a cut-short or stretched pulse before the wrap. It sets the alignment bit while the channel is enabled; a design that switches shape immediately would count past PER−1 instead of wrapping. It also drives the extreme values DTY = 0, DTY above PER and PER = 0 under both polarities, where an off-by-one compare leaves a stray one-tick glitch. Finally, it sets the enable and alignment bits in the same write, which catches a design that latches the alignment from the old control value.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;

    // Register select codes shared by the write and read ports
    typedef enum logic [1:0] {
        SEL_PER = 2'd0,
        SEL_DTY = 2'd1,
        SEL_CNT = 2'd2,
        SEL_CTL = 2'd3
    } pwm_sel_e;

    // Control register layout, bit 2 down to bit 0
    typedef struct packed {
        logic center;
        logic pol;
        logic en;
    } pwm_ctl_t;

    localparam int       CTL_BITS  = 3;
    localparam pwm_ctl_t CTL_RESET = '{center: 1'b0, pol: 1'b1, en: 1'b0};

    // Double-buffered fields
    localparam int NUM_BUF = 2;
    localparam int BUF_PER = 0;
    localparam int BUF_DTY = 1;

    // Counter state carried between the counter and the wave shaper
    typedef struct packed {
        logic down;
        logic wrap;
    } pwm_phase_t;

    // True while the waveform is in its leading phase (level = polarity)
    function automatic logic lead_phase(input logic [31:0] cnt,
                                        input logic [31:0] dty,
                                        input logic        down);
        return down ? (cnt <= dty) : (cnt < dty);
    endfunction

    function automatic pwm_sel_e buf_code(input int idx);
        return (idx == BUF_PER) ? SEL_PER : SEL_DTY;
    endfunction

endpackage

// File: rtl/pwmch_dbuf.sv
module pwmch_dbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         load,
    output logic [W-1:0] shadow_q,
    output logic [W-1:0] active_q
);
    logic [W-1:0] shadow_d;

    always_comb begin
        shadow_d = wr ? wdata : shadow_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            shadow_q <= shadow_d;
            if (load) begin
                active_q <= shadow_d;
            end
        end
    end
endmodule

// File: rtl/pwmch_regs.sv
module pwmch_regs
    import pwmch_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         safe_point,
    output pwm_ctl_t     ctl_q,
    output logic         center_act,
    output logic [W-1:0] per_shadow,
    output logic [W-1:0] dty_shadow,
    output logic [W-1:0] per_act,
    output logic [W-1:0] dty_act
);
    pwm_ctl_t     ctl_d;
    logic         load;
    logic [W-1:0] shadow_arr [NUM_BUF];
    logic [W-1:0] active_arr [NUM_BUF];

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && pwm_sel_e'(wr_sel) == SEL_CTL) begin
            ctl_d = pwm_ctl_t'(wr_data[CTL_BITS-1:0]);
        end
        // a stopped channel passes writes straight through
        load = !ctl_q.en || safe_point;
    end

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_field
        localparam pwm_sel_e CODE = buf_code(g);
        logic hit;
        assign hit = wr_en && (pwm_sel_e'(wr_sel) == CODE);
        pwmch_dbuf #(.W(W)) u_dbuf (
            .clk      (clk),
            .rst      (rst),
            .wr       (hit),
            .wdata    (wr_data),
            .load     (load),
            .shadow_q (shadow_arr[g]),
            .active_q (active_arr[g])
        );
    end

    assign per_shadow = shadow_arr[BUF_PER];
    assign dty_shadow = shadow_arr[BUF_DTY];
    assign per_act    = active_arr[BUF_PER];
    assign dty_act    = active_arr[BUF_DTY];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= CTL_RESET;
            center_act <= CTL_RESET.center;
        end else begin
            ctl_q <= ctl_d;
            if (!ctl_q.en) begin
                center_act <= ctl_d.center;
            end
        end
    end
endmodule

// File: rtl/pwmch_cnt.sv
module pwmch_cnt
    import pwmch_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         en,
    input  logic         center,
    input  logic         cnt_wr,
    input  logic [W-1:0] per_act,
    output logic [W-1:0] cnt_q,
    output pwm_phase_t   phase,
    output logic         period_end
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W:0] cnt_inc;
    logic       at_top;
    logic       per_zero;
    logic       low;
    logic       down_q;

    always_comb begin
        cnt_inc    = {1'b0, cnt_q} + 1'b1;
        at_top     = cnt_inc >= {1'b0, per_act};
        per_zero   = (per_act == '0);
        low        = (cnt_q <= ONE);
        phase.down = down_q;
        phase.wrap = center ? (per_zero || (down_q && low)) : at_top;
        period_end = en && tick && !cnt_wr && phase.wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else if (!en || cnt_wr) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else if (tick) begin
            if (phase.wrap) begin
                cnt_q  <= '0;
                down_q <= 1'b0;
            end else if (center && down_q) begin
                cnt_q <= cnt_q - ONE;
            end else begin
                cnt_q <= cnt_inc[W-1:0];
                if (center && at_top) begin
                    down_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pwmch_wave.sv
module pwmch_wave
    import pwmch_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         en,
    input  logic         pol,
    input  logic         down,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] per_act,
    input  logic [W-1:0] dty_act,
    output logic         wave
);
    logic lead;

    always_comb begin
        lead = lead_phase(32'(cnt), 32'(dty_act), down);
        if (!en || per_act == '0) begin
            wave = !pol;
        end else begin
            wave = lead ? pol : !pol;
        end
    end
endmodule

// File: rtl/pwmch_top.sv
module pwmch_top
    import pwmch_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data,
    output logic         pwm_out
);
    pwm_ctl_t     ctl_q;
    logic         center_act;
    logic [W-1:0] per_shadow;
    logic [W-1:0] dty_shadow;
    logic [W-1:0] per_act;
    logic [W-1:0] dty_act;
    logic [W-1:0] cnt_q;
    pwm_phase_t   phase;
    logic         period_end;
    logic         cnt_wr;
    logic         safe_point;

    assign cnt_wr     = wr_en && (pwm_sel_e'(wr_sel) == SEL_CNT);
    assign safe_point = cnt_wr || period_end;

    pwmch_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .safe_point (safe_point),
        .ctl_q      (ctl_q),
        .center_act (center_act),
        .per_shadow (per_shadow),
        .dty_shadow (dty_shadow),
        .per_act    (per_act),
        .dty_act    (dty_act)
    );

    pwmch_cnt #(.W(W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .en         (ctl_q.en),
        .center     (center_act),
        .cnt_wr     (cnt_wr),
        .per_act    (per_act),
        .cnt_q      (cnt_q),
        .phase      (phase),
        .period_end (period_end)
    );

    pwmch_wave #(.W(W)) u_wave (
        .en      (ctl_q.en),
        .pol     (ctl_q.pol),
        .down    (phase.down),
        .cnt     (cnt_q),
        .per_act (per_act),
        .dty_act (dty_act),
        .wave    (pwm_out)
    );

    always_comb begin
        unique case (pwm_sel_e'(rd_sel))
            SEL_PER: rd_data = per_shadow;
            SEL_DTY: rd_data = dty_shadow;
            SEL_CNT: rd_data = cnt_q;
            SEL_CTL: rd_data = W'(ctl_q);
        endcase
    end
endmodule

// File: rtl/pwmch_chk.sv
module pwmch_chk
    import pwmch_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic         en,
    input logic         pol,
    input logic         center_act,
    input logic [W-1:0] cnt,
    input logic [W-1:0] per_act,
    input logic [W-1:0] dty_act,
    input logic         pwm_out
);
    logic cw;
    assign cw = wr_en && (wr_sel == 2'd2);

    // R8
    stopped_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> cnt == '0);

    // R8
    stopped_level_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> pwm_out == !pol);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> cnt <= per_act);

    // R11
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        en && !tick && !cw |=> $stable(cnt));

    // R6
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        en && !tick && !cw |=> $stable(dty_act) && $stable(per_act));

    // R2
    edge_step_chk: assert property (@(posedge clk) disable iff (rst)
        en && !center_act && tick && !cw && (({1'b0, cnt} + 1'b1) < {1'b0, per_act})
        |=> cnt == $past(cnt) + 1'b1);

    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cw |=> cnt == '0);

    // R5
    full_level_chk: assert property (@(posedge clk) disable iff (rst)
        en && per_act != '0 && dty_act >= per_act |-> pwm_out == pol);
endmodule

bind pwmch_top pwmch_chk #(.W(W)) u_pwmch_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .en         (ctl_q.en),
    .pol        (ctl_q.pol),
    .center_act (center_act),
    .cnt        (cnt_q),
    .per_act    (per_act),
    .dty_act    (dty_act),
    .pwm_out    (pwm_out)
);

// File: tb/pwmch_top_bench.sv
`timescale 1ns/1ps
module pwmch_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       pwm_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // model state
    int m_pb, m_db, m_pa, m_da, m_cnt;
    bit m_down, m_cen, m_en, m_cw, m_pe;
    bit [2:0] m_ctl, n_ctl;
    int n_pb, n_db;

    always #2.5 clk = ~clk;

    pwmch_top u_pwmch_top (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_pb = 0; m_db = 0; m_pa = 0; m_da = 0; m_cnt = 0;
            m_down = 0; m_cen = 0; m_ctl = 3'b010;
        end else begin
            m_en = m_ctl[0];
            m_cw = wr_en && wr_sel == 2'd2;
            n_pb = (wr_en && wr_sel == 2'd0) ? int'(wr_data) : m_pb;
            n_db = (wr_en && wr_sel == 2'd1) ? int'(wr_data) : m_db;
            n_ctl = (wr_en && wr_sel == 2'd3) ? wr_data[2:0] : m_ctl;
            m_pe = 0;
            if (!m_en || m_cw) begin
                m_cnt = 0; m_down = 0;
            end else if (tick) begin
                if (!m_cen) begin
                    if (m_cnt + 1 >= m_pa) begin m_cnt = 0; m_pe = 1; end
                    else m_cnt = m_cnt + 1;
                end else if (m_pa == 0) begin
                    m_cnt = 0; m_down = 0; m_pe = 1;
                end else if (!m_down) begin
                    m_cnt = m_cnt + 1;
                    if (m_cnt >= m_pa) m_down = 1;
                end else if (m_cnt <= 1) begin
                    m_cnt = 0; m_down = 0; m_pe = 1;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            if (!m_en || m_cw || m_pe) begin m_pa = n_pb; m_da = n_db; end
            if (!m_en) m_cen = n_ctl[2];
            m_pb = n_pb; m_db = n_db; m_ctl = n_ctl;
        end
    end

    function automatic bit exp_out();
        bit lead;
        if (!m_ctl[0] || m_pa == 0) return !m_ctl[1];
        lead = (m_cen && m_down) ? (m_cnt <= m_da) : (m_cnt < m_da);
        return lead ? m_ctl[1] : !m_ctl[1];
    endfunction

    function automatic int exp_rd(input bit [1:0] s);
        case (s)
            2'd0: return m_pb;
            2'd1: return m_db;
            2'd2: return m_cnt;
            default: return int'(m_ctl);
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one clock: drive, update, compare with model
    task automatic step(input bit tk, input bit we, input bit [1:0] sel,
                        input bit [7:0] d, input bit [1:0] rs, input string tag);
        tick = tk; wr_en = we; wr_sel = sel; wr_data = d; rd_sel = rs;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk(pwm_out == exp_out(), tag, "model out", int'(pwm_out), int'(exp_out()));
        chk(int'(rd_data) == exp_rd(rs), tag, "model rd", int'(rd_data), exp_rd(rs));
    endtask

    task automatic wr(input bit [1:0] sel, input bit [7:0] d, input string tag);
        step(1'b0, 1'b1, sel, d, 2'd2, tag);
    endtask

    task automatic tk1(input string tag);
        step(1'b1, 1'b0, 2'd0, 8'd0, 2'd2, tag);
    endtask

    task automatic rd_expect(input bit [1:0] s, input int exp, input string tag);
        rd_sel = s;
        #0.5;
        chk(int'(rd_data) == exp, tag, "readback", int'(rd_data), exp);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int highs;
        int cseq [7] = '{1, 2, 3, 2, 1, 0, 1};
        int oseq [7] = '{0, 0, 0, 0, 1, 1, 0};
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);

        // R1 reset state
        chk(pwm_out == 1'b0, "R1", "out", int'(pwm_out), 0);
        rd_expect(2'd0, 0, "R1");
        rd_expect(2'd1, 0, "R1");
        rd_expect(2'd2, 0, "R1");
        rd_expect(2'd3, 2, "R1");

        // R8 disabled writes go through; output at inverse polarity
        wr(2'd0, 8'd5, "R8");
        wr(2'd1, 8'd2, "R8");
        for (int i = 0; i < 3; i++) tk1("R8");
        chk(pwm_out == 1'b0, "R8", "stopped out pol1", int'(pwm_out), 0);
        rd_expect(2'd2, 0, "R8");
        wr(2'd3, 8'd0, "R8");
        chk(pwm_out == 1'b1, "R8", "stopped out pol0", int'(pwm_out), 1);

        // R2 / R4 edge-aligned, PER=5, DTY=2, pol 1
        wr(2'd3, 8'd3, "R2");
        chk(pwm_out == 1'b1, "R4", "start level", int'(pwm_out), 1);
        highs = 0;
        for (int k = 1; k <= 12; k++) begin
            tk1("R2");
            rd_expect(2'd2, k % 5, "R2");
            if (k <= 10 && pwm_out) highs++;
        end
        chk(highs == 4, "R4", "high ticks in two periods", highs, 4);

        // R6 / R9 mid-period duty change (counter now 2)
        wr(2'd1, 8'd4, "R9");
        rd_expect(2'd1, 4, "R9");
        chk(pwm_out == 1'b0, "R6", "old duty still active", int'(pwm_out), 0);
        tk1("R6");
        tk1("R6");
        chk(pwm_out == 1'b0, "R6", "old duty to period end", int'(pwm_out), 0);
        tk1("R6");
        rd_expect(2'd2, 0, "R6");
        for (int k = 1; k <= 3; k++) begin
            tk1("R6");
            chk(pwm_out == 1'b1, "R6", "new duty high", int'(pwm_out), 1);
        end

        // R7 counter write clears and loads new period
        wr(2'd0, 8'd3, "R7");
        wr(2'd2, 8'd99, "R7");
        rd_expect(2'd2, 0, "R7");
        tk1("R7"); tk1("R7"); tk1("R7");
        rd_expect(2'd2, 0, "R7");

        // R11 no tick, no motion
        tk1("R11");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 2'd0, 8'd0, 2'd2, "R11");
        rd_expect(2'd2, 1, "R11");

        // R10 alignment change while running is deferred
        wr(2'd3, 8'd7, "R10");
        wr(2'd2, 8'd0, "R10");
        tk1("R10"); tk1("R10");
        rd_expect(2'd2, 2, "R10");
        tk1("R10");
        rd_expect(2'd2, 0, "R10");

        // R3 centre-aligned, PER=3, DTY=1, pol 1
        wr(2'd3, 8'd6, "R3");
        wr(2'd1, 8'd1, "R3");
        wr(2'd3, 8'd7, "R3");
        chk(pwm_out == 1'b1, "R3", "start level", int'(pwm_out), 1);
        for (int k = 0; k < 7; k++) begin
            tk1("R3");
            rd_expect(2'd2, cseq[k], "R3");
            chk(int'(pwm_out) == oseq[k], "R3", "centre out", int'(pwm_out), oseq[k]);
        end

        // R5 boundary values
        wr(2'd3, 8'd2, "R5"); wr(2'd1, 8'd0, "R5"); wr(2'd0, 8'd6, "R5"); wr(2'd3, 8'd3, "R5");
        for (int k = 0; k < 8; k++) begin
            tk1("R5");
            chk(pwm_out == 1'b0, "R5", "dty zero", int'(pwm_out), 0);
        end
        wr(2'd3, 8'd2, "R5"); wr(2'd1, 8'd9, "R5"); wr(2'd3, 8'd3, "R5");
        for (int k = 0; k < 8; k++) begin
            tk1("R5");
            chk(pwm_out == 1'b1, "R5", "dty above per", int'(pwm_out), 1);
        end
        wr(2'd3, 8'd1, "R5");
        for (int k = 0; k < 4; k++) begin
            tk1("R5");
            chk(pwm_out == 1'b0, "R5", "dty above per pol0", int'(pwm_out), 0);
        end
        wr(2'd3, 8'd2, "R5"); wr(2'd0, 8'd0, "R5"); wr(2'd3, 8'd3, "R5");
        for (int k = 0; k < 4; k++) begin
            tk1("R5");
            chk(pwm_out == 1'b0, "R5", "per zero", int'(pwm_out), 0);
        end

        // random mix against the model (R4, R6)
        for (int i = 0; i < 6000; i++) begin
            bit tkr, wer;
            bit [1:0] s;
            bit [7:0] d;
            tkr = ($urandom % 10) < 6;
            wer = ($urandom % 8) == 0;
            s = 2'($urandom % 4);
            if (s == 2'd3) begin
                d = 8'($urandom % 8);
                if (($urandom % 5) != 0) d[0] = 1'b1;
            end else begin
                d = 8'($urandom % 13);
            end
            step(tkr, wer, s, d, 2'($urandom % 4), "R4");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule